// File: doc/BRIEF.md
# Shared-Pin Sigma-Delta ADC Interface Emulator

This block is a synthesizable, device-side stand-in for the digital interface of a sigma-delta converter. That converter uses a single output pin for two jobs: it flags that a result is ready and it carries the serial data. It is meant to sit in a test environment opposite a host reader under verification. From the system clock it derives a conversion time base whose update rate is picked by a filter-select input. On every update it captures a supplied data value and status byte into a 32-bit word and pulls the shared line low. The host then clocks the word out on SCLK, all at once or in several batches.

The model drives new data after each SCLK falling edge, so the host samples on the rising edge. The line returns high once the whole word has been read. It also returns high shortly before the next update if the host has not started reading the result. Each update restarts the shifter, even if a read is still in progress. An active-low power-down/reset input clears all state and releases the pin, modelled as an output enable. After that input rises, the block waits through a power-up delay and then converts continuously. Every time constant is a parameter scaled from the clock frequency.

Top module: `shared_pin_adc_emu`

## Requirements
- R1: While `pdRstN` is low, `sdoOe` is 0 and all state is cleared. One clock edge after `pdRstN` goes high, `sdoOe` is 1 and `sdoOut` is 1.
- R2: After `pdRstN` rises, the first conversion takes effect on clock edge PU + P. Here PU = floor(CLK_HZ*POWERUP_US/1e6) and P is the period of the selected filter. `sdoOut` stays high before that edge.
- R3: The conversion period is floor(CLK_HZ*10/FAST_X10) cycles when `slowFilter` is 0 and floor(CLK_HZ*10/SLOW_X10) cycles when it is 1. The defaults are FAST_X10=167 and SLOW_X10=100. The selection is applied to the running period, so a change made just after an update sets the length of the next period.
- R4: On each conversion the word {convData[23:0], convStatus[7:0]} is captured, data in the upper bits and status in the lowest 8 bits. `sdoOut` is driven low on the same edge. Later changes to the inputs do not alter the captured word.
- R5: SCLK is passed through two synchronizing flops. Each falling edge presents the next word bit on `sdoOut` two clock edges later, MSB first. This continues for 32 bits, and pauses between SCLK batches are allowed.
- R6: On the SCLK rising edge that follows the 32nd bit, `sdoOut` returns high. It stays high until the next conversion.
- R7: If no SCLK falling edge has been seen since a conversion, `sdoOut` returns high LEAD = floor(CLK_HZ*RELEASE_US/1e6) cycles before the next conversion.
- R8: A conversion restarts the shifter even in the middle of a read. A read that has already started is not released at the LEAD point: the line keeps the last shifted bit until the conversion.
- R9: SCLK edges are ignored while the line is idle high. They consume no bits, so the next read still begins at the MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for all logic and timers |
| pdRstN | input | 1 | Active-low power-down and reset; asynchronous clear |
| slowFilter | input | 1 | Filter select: 0 fast update rate, 1 slow update rate |
| sclk | input | 1 | Host serial clock, idle high, asynchronous to clk |
| convData | input | DATA_W | Conversion value captured at each update |
| convStatus | input | STATUS_W | Status byte captured at each update |
| sdoOut | output | 1 | Shared ready/data line value |
| sdoOe | output | 1 | Output enable of the shared line; 0 means high impedance |

## Verification
The bench builds the block with CLK_HZ = 20000 and keeps the other parameters at their defaults. That gives fast and slow periods of 1197 and 2000 cycles, and a power-up delay and release lead of 20 cycles each. With these values a single run covers a dozen conversions, switches between the two filters, goes through a full power cycle and releases an unread result. The bench checks each update edge and each release edge to the exact cycle. Its read timing is randomised and still ends well inside one period.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

  // Strobes from control to datapath; at most one is active per cycle.
  typedef struct packed {
    logic load;   // capture a new word, line low
    logic shift;  // present next bit on the line
    logic idle;   // return the line high
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READY = 2'd1,
    ST_SHIFT = 2'd2
  } emuState_t;

endpackage

// File: rtl/adc_emu_timebase.sv
module adc_emu_timebase #(
  parameter int unsigned CLK_HZ     = 1_000_000,
  parameter int unsigned FAST_X10   = 167,
  parameter int unsigned SLOW_X10   = 100,
  parameter int unsigned POWERUP_US = 1000,
  parameter int unsigned RELEASE_US = 1000
) (
  input  logic clk,
  input  logic pdRstN,
  input  logic slowFilter,
  output logic convTick,
  output logic leadTick,
  output logic powered
);

  localparam longint FAST_L = (longint'(CLK_HZ) * 10) / longint'(FAST_X10);
  localparam longint SLOW_L = (longint'(CLK_HZ) * 10) / longint'(SLOW_X10);
  localparam longint PU_L   = (longint'(CLK_HZ) * longint'(POWERUP_US)) / 1000000;
  localparam longint LEAD_L = (longint'(CLK_HZ) * longint'(RELEASE_US)) / 1000000;
  localparam int FAST_CYC = int'(FAST_L);
  localparam int SLOW_CYC = int'(SLOW_L);
  localparam int PU_CYC   = (PU_L < 1) ? 1 : int'(PU_L);
  localparam int LEAD_CYC = int'(LEAD_L);
  localparam int MAX_CYC  = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);
  localparam int PU_W     = $clog2(PU_CYC + 1);

  logic [CNT_W-1:0] rateCnt;
  logic [PU_W-1:0]  puCnt;
  logic [CNT_W-1:0] periodLast;
  logic [CNT_W-1:0] leadPoint;

  assign periodLast = slowFilter ? CNT_W'(SLOW_CYC - 1) : CNT_W'(FAST_CYC - 1);
  assign leadPoint  = slowFilter ? CNT_W'(SLOW_CYC - 1 - LEAD_CYC)
                                 : CNT_W'(FAST_CYC - 1 - LEAD_CYC);

  assign powered  = (puCnt == PU_W'(PU_CYC));
  assign convTick = powered && (rateCnt >= periodLast);
  assign leadTick = powered && (rateCnt == leadPoint);

  always_ff @(posedge clk or negedge pdRstN) begin
    if (!pdRstN) begin
      puCnt   <= '0;
      rateCnt <= '0;
    end else if (!powered) begin
      puCnt <= puCnt + PU_W'(1);
    end else if (convTick) begin
      rateCnt <= '0;
    end else begin
      rateCnt <= rateCnt + CNT_W'(1);
    end
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!pdRstN)
    convTick |=> !convTick); // R3

  AST_LEAD_APART: assert property (@(posedge clk) disable iff (!pdRstN)
    leadTick |-> !convTick); // R7

endmodule

// File: rtl/adc_emu_ctrl.sv
module adc_emu_ctrl
  import adc_emu_pkg::*;
(
  input  logic       clk,
  input  logic       pdRstN,
  input  logic       sclk,
  input  logic       convTick,
  input  logic       leadTick,
  input  logic       wordDone,
  output ctlStrobe_t strobe,
  output logic       waiting,
  output logic       oeOut
);

  logic      sclkMeta;
  logic      sclkSync;
  logic      sclkFall;
  logic      sclkRise;
  emuState_t state;
  emuState_t stateNext;

  // Two-flop synchronizer; SCLK idles high.
  always_ff @(posedge clk or negedge pdRstN) begin
    if (!pdRstN) begin
      sclkMeta <= 1'b1;
      sclkSync <= 1'b1;
    end else begin
      sclkMeta <= sclk;
      sclkSync <= sclkMeta;
    end
  end

  assign sclkFall = sclkSync & ~sclkMeta;
  assign sclkRise = ~sclkSync & sclkMeta;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (convTick) begin
          strobe.load = 1'b1;
          stateNext   = ST_READY;
        end
      end
      ST_READY: begin
        if (convTick) begin
          strobe.load = 1'b1;
        end else if (leadTick) begin
          strobe.idle = 1'b1;
          stateNext   = ST_IDLE;
        end else if (sclkFall) begin
          strobe.shift = 1'b1;
          stateNext    = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (convTick) begin
          strobe.load = 1'b1;
          stateNext   = ST_READY;
        end else if (sclkFall && !wordDone) begin
          strobe.shift = 1'b1;
        end else if (sclkRise && wordDone) begin
          strobe.idle = 1'b1;
          stateNext   = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge pdRstN) begin
    if (!pdRstN) begin
      state <= ST_IDLE;
      oeOut <= 1'b0;
    end else begin
      state <= stateNext;
      oeOut <= 1'b1;
    end
  end

  assign waiting = (state == ST_READY);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!pdRstN)
    $onehot0({strobe.load, strobe.shift, strobe.idle})); // R8

  AST_CONV_WINS: assert property (@(posedge clk) disable iff (!pdRstN)
    convTick |-> strobe.load); // R8

  AST_IDLE_DEAF: assert property (@(posedge clk) disable iff (!pdRstN)
    (state == ST_IDLE) |-> !strobe.shift); // R9

endmodule

// File: rtl/adc_emu_datapath.sv
module adc_emu_datapath
  import adc_emu_pkg::*;
#(
  parameter int unsigned DATA_W   = 24,
  parameter int unsigned STATUS_W = 8
) (
  input  logic                clk,
  input  logic                pdRstN,
  input  ctlStrobe_t          strobe,
  input  logic [DATA_W-1:0]   convData,
  input  logic [STATUS_W-1:0] convStatus,
  output logic                lineOut,
  output logic                wordDone
);

  localparam int WORD_W = DATA_W + STATUS_W;
  localparam int BC_W   = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] shiftReg;
  logic [BC_W-1:0]   bitCnt;
  logic              lineQ;

  always_ff @(posedge clk or negedge pdRstN) begin
    if (!pdRstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      lineQ    <= 1'b1;
    end else if (strobe.load) begin
      shiftReg <= {convData, convStatus};
      bitCnt   <= '0;
      lineQ    <= 1'b0;
    end else if (strobe.shift) begin
      lineQ    <= shiftReg[WORD_W-1];
      shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
      bitCnt   <= bitCnt + BC_W'(1);
    end else if (strobe.idle) begin
      lineQ <= 1'b1;
    end
  end

  assign lineOut  = lineQ;
  assign wordDone = (bitCnt == BC_W'(WORD_W));

  AST_BITS_BOUNDED: assert property (@(posedge clk) disable iff (!pdRstN)
    bitCnt <= BC_W'(WORD_W)); // R5

  AST_NO_OVERSHIFT: assert property (@(posedge clk) disable iff (!pdRstN)
    strobe.shift |-> !wordDone); // R5

endmodule

// File: rtl/shared_pin_adc_emu.sv
module shared_pin_adc_emu
  import adc_emu_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 1_000_000,
  parameter int unsigned FAST_X10   = 167,
  parameter int unsigned SLOW_X10   = 100,
  parameter int unsigned POWERUP_US = 1000,
  parameter int unsigned RELEASE_US = 1000,
  parameter int unsigned DATA_W     = 24,
  parameter int unsigned STATUS_W   = 8
) (
  input  logic                clk,
  input  logic                pdRstN,
  input  logic                slowFilter,
  input  logic                sclk,
  input  logic [DATA_W-1:0]   convData,
  input  logic [STATUS_W-1:0] convStatus,
  output logic                sdoOut,
  output logic                sdoOe
);

  logic       convTick;
  logic       leadTick;
  logic       powered;
  logic       wordDone;
  logic       waiting;
  ctlStrobe_t strobe;

  adc_emu_timebase #(
    .CLK_HZ    (CLK_HZ),
    .FAST_X10  (FAST_X10),
    .SLOW_X10  (SLOW_X10),
    .POWERUP_US(POWERUP_US),
    .RELEASE_US(RELEASE_US)
  ) timebase_i (
    .clk       (clk),
    .pdRstN    (pdRstN),
    .slowFilter(slowFilter),
    .convTick  (convTick),
    .leadTick  (leadTick),
    .powered   (powered)
  );

  adc_emu_ctrl ctrl_i (
    .clk     (clk),
    .pdRstN  (pdRstN),
    .sclk    (sclk),
    .convTick(convTick),
    .leadTick(leadTick),
    .wordDone(wordDone),
    .strobe  (strobe),
    .waiting (waiting),
    .oeOut   (sdoOe)
  );

  adc_emu_datapath #(
    .DATA_W  (DATA_W),
    .STATUS_W(STATUS_W)
  ) datapath_i (
    .clk       (clk),
    .pdRstN    (pdRstN),
    .strobe    (strobe),
    .convData  (convData),
    .convStatus(convStatus),
    .lineOut   (sdoOut),
    .wordDone  (wordDone)
  );

  AST_DRIVEN_AFTER_RESET: assert property (@(posedge clk) disable iff (!pdRstN)
    1'b1 |=> sdoOe); // R1

  AST_QUIET_UNTIL_POWERED: assert property (@(posedge clk) disable iff (!pdRstN)
    !powered |-> sdoOut); // R2

  AST_READY_LOW: assert property (@(posedge clk) disable iff (!pdRstN)
    convTick |=> !sdoOut); // R4

  AST_UNREAD_RELEASE: assert property (@(posedge clk) disable iff (!pdRstN)
    (leadTick && waiting && !convTick) |=> sdoOut); // R7

endmodule

// File: tb/shared_pin_adc_emu_tb_top.sv
module shared_pin_adc_emu_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 20000;
  localparam int FAST_CYC   = (CLK_HZ * 10) / 167;
  localparam int SLOW_CYC   = (CLK_HZ * 10) / 100;
  localparam int PU_CYC     = (CLK_HZ * 1000) / 1000000;
  localparam int LEAD_CYC   = (CLK_HZ * 1000) / 1000000;

  logic        clk = 1'b0;
  logic        pdRstN = 1'b0;
  logic        slowFilter = 1'b0;
  logic        sclk = 1'b1;
  logic [23:0] convData = '0;
  logic [7:0]  convStatus = '0;
  logic        sdoOut;
  logic        sdoOe;

  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  int          nextConv = 0;
  logic [31:0] curWord = '0;

  shared_pin_adc_emu #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk       (clk),
    .pdRstN    (pdRstN),
    .slowFilter(slowFilter),
    .sclk      (sclk),
    .convData  (convData),
    .convStatus(convStatus),
    .sdoOut    (sdoOut),
    .sdoOe     (sdoOe)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int periodOf(input logic slow);
    return slow ? SLOW_CYC : FAST_CYC;
  endfunction

  function automatic logic [31:0] wordOf(input logic [23:0] d, input logic [7:0] s);
    return {d, s};
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitTo(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic newInputs();
    convData   = 24'($urandom);
    convStatus = 8'($urandom);
  endtask

  // Wait for the expected conversion edge, check ready, pick next filter.
  task automatic awaitConv(input string req, input logic nextSlow);
    waitTo(nextConv);
    chk(req, "ready low at conversion", longint'(sdoOut), 0);
    curWord = wordOf(convData, convStatus);
    newInputs();
    slowFilter = nextSlow;
    nextConv = nextConv + periodOf(nextSlow);
  endtask

  task automatic pulse();
    @(negedge clk) sclk = 1'b0;
    repeat (3) @(negedge clk);
    sclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic readBits(input int n, output logic [31:0] w);
    int left;
    left = n;
    w = '0;
    while (left > 0) begin
      int batch;
      batch = 1 + int'($urandom % 8);
      if (batch > left) batch = left;
      for (int i = 0; i < batch; i++) begin
        @(negedge clk) sclk = 1'b0;
        repeat (3) @(negedge clk);
        w = {w[30:0], sdoOut};
        sclk = 1'b1;
        repeat (3) @(negedge clk);
      end
      left -= batch;
      repeat (int'($urandom % 12)) @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic        lastBit;
    int          base;
    void'($urandom(32'h5EED_0A1D));
    newInputs();

    // R1: held in power-down
    repeat (3) @(negedge clk);
    chk("R1", "oe during power-down", longint'(sdoOe), 0);

    pdRstN = 1'b1;
    base = cyc;
    @(negedge clk);
    chk("R1", "oe after release", longint'(sdoOe), 1);
    chk("R1", "line idle after release", longint'(sdoOut), 1);

    // R2: power-up delay plus one fast period
    nextConv = base + PU_CYC + FAST_CYC;
    waitTo(nextConv - 1);
    chk("R2", "line high before first conversion", longint'(sdoOut), 1);
    awaitConv("R2", 1'b0);

    // R3 R4 R5 R6 R9: random batched reads, random filter choice
    for (int k = 0; k < 6; k++) begin
      readBits(32, w);
      chk("R5", "word read MSB first", longint'(w), longint'(curWord));
      chk("R6", "line high after last bit", longint'(sdoOut), 1);
      pulse();
      pulse();
      chk("R9", "idle pulses ignored", longint'(sdoOut), 1);
      waitTo(nextConv - 1);
      chk("R3", "line high one cycle before update", longint'(sdoOut), 1);
      awaitConv("R3", 1'($urandom % 2));
    end

    // R7: unread result released LEAD cycles early
    waitTo(nextConv - LEAD_CYC - 1);
    chk("R7", "still ready before lead point", longint'(sdoOut), 0);
    waitTo(nextConv - LEAD_CYC);
    chk("R7", "released at lead point", longint'(sdoOut), 1);
    pulse();
    pulse();
    chk("R9", "pulses in release window ignored", longint'(sdoOut), 1);
    awaitConv("R7", 1'b0);
    readBits(32, w);
    chk("R9", "full word after ignored pulses", longint'(w), longint'(curWord));

    // Prepare: word bit 22 (data bit 14) forced to 0 for the next capture
    convData[14] = 1'b0;
    awaitConv("R4", 1'b0);

    // R8: read in progress is kept, then reset by the conversion
    readBits(10, w);
    chk("R8", "first ten bits", longint'(w[9:0]), longint'(curWord[31:22]));
    lastBit = curWord[22];
    waitTo(nextConv - LEAD_CYC);
    chk("R8", "no release during read", longint'(sdoOut), longint'(lastBit));
    waitTo(nextConv - 1);
    chk("R8", "last bit held to update", longint'(sdoOut), longint'(lastBit));
    awaitConv("R8", 1'b1);
    readBits(32, w);
    chk("R8", "word after restart", longint'(w), longint'(curWord));

    // R1 R2: power cycle, then slow filter start
    @(negedge clk) pdRstN = 1'b0;
    @(negedge clk);
    chk("R1", "oe cleared by power-down", longint'(sdoOe), 0);
    repeat (5) @(negedge clk);
    pdRstN = 1'b1;
    slowFilter = 1'b1;
    base = cyc;
    nextConv = base + PU_CYC + SLOW_CYC;
    @(negedge clk);
    chk("R1", "oe restored", longint'(sdoOe), 1);
    waitTo(nextConv - 1);
    chk("R2", "quiet through slow power-up", longint'(sdoOut), 1);
    awaitConv("R2", 1'b1);
    readBits(32, w);
    chk("R4", "word after power cycle", longint'(w), longint'(curWord));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule